// File: doc/BRIEF.md
# Three-Pole Three-Zero Digital Compensator

This block closes the loop of a digitally controlled power stage. Each time a new feedback conversion is ready, a start strobe hands it a 12-bit setpoint and a 12-bit feedback sample. It forms the control error and evaluates a third-order linear difference equation over the present error, the three previous errors and the three previous outputs. A single multiplier-accumulator does the work, one product per clock. The sum is multiplied by a programmable gain, shifted right and limited to a programmable window. The result appears on the duty output, together with a one-cycle done strobe that tells the modulator a fresh command is ready.

The seven coefficients, the gain, the shift and the two limits are written through a small address/data write port while the block is idle. A clear input empties the error and output histories, for example when the converter restarts. An abort input cancels a computation in progress and leaves the loop state as it was.

Top module: `comp3p3z`

## Requirements
- R1: The error is setpoint minus sample, both unsigned 12-bit, taken as a signed 13-bit value on the clock edge that accepts a start.
- R2: The accumulated sum is B0*e[n] + B1*e[n-1] + B2*e[n-2] + B3*e[n-3] + A1*u[n-1] + A2*u[n-2] + A3*u[n-3], with signed 16-bit coefficients, added in that order.
- R3: A start is accepted when the block is idle and abort is low. busy is high from the next cycle. done is a one-cycle pulse that rises 8 clocks after the accepting edge, and busy falls on the same edge.
- R4: The accumulator is 32-bit signed and saturates at its extremes after every addition instead of wrapping.
- R5: The sum is multiplied by the signed 16-bit gain and then shifted right arithmetically by 0 to 31 places, so the result rounds toward minus infinity.
- R6: A scaled value above the maximum limit gives the maximum. Otherwise a value below the minimum limit gives the minimum. duty changes only on the edge that raises done.
- R7: When a computation completes, e[n] becomes the newest error history entry and the clamped duty becomes the newest output history entry. Older entries move back one place.
- R8: hist_clr while idle sets all six history entries to zero. A start in the same cycle computes with the cleared histories.
- R9: abort while busy ends the computation. No done follows, and duty and both histories keep their values.
- R10: Write addresses: 0 to 3 hold B0 to B3, 4 to 6 hold A1 to A3, 7 the gain, 8 the shift (bits 4:0), 9 the minimum and 10 the maximum limit, all signed. After reset the coefficients are 0, the gain 1, the shift 0, the minimum 0 and the maximum 32767. Writes while busy are ignored.
- R11: A start while busy is ignored and does not disturb the computation in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 16 | Configuration write data |
| hist_clr | input | 1 | Clear error and output histories (idle only) |
| start | input | 1 | Begin one update with the present setpoint and sample |
| abort | input | 1 | Cancel the update in progress |
| setpoint | input | 12 | Control reference |
| sample | input | 12 | Latest feedback conversion |
| busy | output | 1 | Update in progress |
| done | output | 1 | One-cycle strobe, duty holds a new value |
| duty | output | 16 | Clamped duty-cycle command, signed |

## Verification
The embedded assertions watch, on every cycle, the handshake timing, the one-cycle done pulse, abort and start-while-busy handling, and that the accumulator never changes sign on an addition that should push it further the same way. They also check that duty stays inside the limit window and holds between updates, that history clears take effect, and that configuration stays frozen while busy. The numeric result can only be judged by the bench scenarios, which compare each output with an arithmetic model. These scenarios cover error sweeps across the full sample range, mixed coefficient sets over several updates, every shift amount, clamp windows, and saturation in both directions. They also show that clears, aborts, late starts and late writes leave exactly the expected history behind.

// File: rtl/comp_pkg.sv
// comp_pkg: shared constants for the three-pole three-zero compensator.
// Assumes four error taps and three output taps; the register address
// layout places the coefficients first, in tap order.
package comp_pkg;
    localparam int NUM_B  = 4;              // error taps (current + 3 past)
    localparam int NUM_A  = 3;              // past output taps
    localparam int NTERM  = NUM_B + NUM_A;  // products per update
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] REG_SCALE = 4'd7;
    localparam logic [ADDR_W-1:0] REG_SHIFT = 4'd8;
    localparam logic [ADDR_W-1:0] REG_LO    = 4'd9;
    localparam logic [ADDR_W-1:0] REG_HI    = 4'd10;
endpackage

// File: rtl/comp_cfg.sv
// comp_cfg: configuration registers (coefficients, gain, shift, limits).
// Assumes writes are only meaningful while idle; writes during busy are
// dropped so a computation always sees one consistent parameter set.
module comp_cfg
    import comp_pkg::*;
#(
    parameter int DW   = 16,
    parameter int SH_W = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       busy,
    input  logic                       we,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DW-1:0]              wdata,
    output logic [NTERM-1:0][DW-1:0]   coef,
    output logic [DW-1:0]              scale,
    output logic [SH_W-1:0]            shift,
    output logic [DW-1:0]              lo,
    output logic [DW-1:0]              hi
);
    logic wr_ok;
    assign wr_ok = we && !busy;

    // One register per coefficient tap, addressed by tap index
    for (genvar i = 0; i < NTERM; i++) begin : g_coef
        logic [DW-1:0] q;
        // Hold tap i coefficient
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (wr_ok && addr == ADDR_W'(i))
                q <= wdata;
        end
        assign coef[i] = q;
    end

    // Hold post-processing gain, shift and clamp limits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scale <= DW'(1);
            shift <= '0;
            lo    <= '0;
            hi    <= {1'b0, {(DW-1){1'b1}}};
        end else if (wr_ok) begin
            case (addr)
                REG_SCALE: scale <= wdata;
                REG_SHIFT: shift <= wdata[SH_W-1:0];
                REG_LO:    lo    <= wdata;
                REG_HI:    hi    <= wdata;
                default:   ;
            endcase
        end
    end

    // R10
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && we |=> $stable(coef) && $stable(scale) && $stable(shift)
                       && $stable(lo) && $stable(hi));
endmodule

// File: rtl/comp_hist.sv
// comp_hist: error and output histories plus the operand selector.
// Captures the new error on accept, advances both delay lines only when
// an update completes, clears them on request, and presents the operand
// for the current step (0 = newest error ... NTERM-1 = oldest output).
module comp_hist
    import comp_pkg::*;
#(
    parameter int SAMP_W = 12,
    parameter int DW     = 16,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [SAMP_W-1:0] setpoint,
    input  logic [SAMP_W-1:0] sample,
    input  logic              clr,
    input  logic              advance,
    input  logic [DW-1:0]     newest,
    input  logic [SEL_W-1:0]  sel,
    output logic [DW-1:0]     operand
);
    localparam int ERR_W  = SAMP_W + 1;
    localparam int NSLOTS = 2 ** SEL_W;

    logic signed [ERR_W-1:0]       err_now;
    logic [DW-1:0]                 e_cur;
    logic [NUM_B-2:0][DW-1:0]      e_h;
    logic [NUM_B-2:0][DW-1:0]      e_src;
    logic [NUM_A-1:0][DW-1:0]      u_h;
    logic [NUM_A-1:0][DW-1:0]      u_src;
    logic [NSLOTS-1:0][DW-1:0]     ops;

    assign err_now = $signed({1'b0, setpoint}) - $signed({1'b0, sample});

    // Latch the sign-extended error of the accepted sample
    always_ff @(posedge clk) begin
        if (!rst_n)
            e_cur <= '0;
        else if (capture)
            e_cur <= {{(DW-ERR_W){err_now[ERR_W-1]}}, err_now};
    end

    // Error delay line: stage 0 takes the current error
    for (genvar i = 0; i < NUM_B-1; i++) begin : g_err
        if (i == 0) begin : g_head
            assign e_src[i] = e_cur;
        end else begin : g_tail
            assign e_src[i] = e_h[i-1];
        end
        // Advance on completion, zero on clear
        always_ff @(posedge clk) begin
            if (!rst_n)
                e_h[i] <= '0;
            else if (advance)
                e_h[i] <= e_src[i];
            else if (clr)
                e_h[i] <= '0;
        end
    end

    // Output delay line: stage 0 takes the clamped duty
    for (genvar j = 0; j < NUM_A; j++) begin : g_out
        if (j == 0) begin : g_head
            assign u_src[j] = newest;
        end else begin : g_tail
            assign u_src[j] = u_h[j-1];
        end
        // Advance on completion, zero on clear
        always_ff @(posedge clk) begin
            if (!rst_n)
                u_h[j] <= '0;
            else if (advance)
                u_h[j] <= u_src[j];
            else if (clr)
                u_h[j] <= '0;
        end
    end

    // Operand table indexed by step, unused slots read as zero
    for (genvar k = 0; k < NSLOTS; k++) begin : g_ops
        if (k == 0) begin : g_now
            assign ops[k] = e_cur;
        end else if (k < NUM_B) begin : g_eh
            assign ops[k] = e_h[k-1];
        end else if (k < NTERM) begin : g_uh
            assign ops[k] = u_h[k-NUM_B];
        end else begin : g_pad
            assign ops[k] = '0;
        end
    end

    assign operand = ops[sel];

    // R8
    hist_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr && !advance |=> (e_h == '0) && (u_h == '0));

    // R7
    hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr && !advance |=> $stable(e_h) && $stable(u_h));
endmodule

// File: rtl/comp_mac.sv
// comp_mac: signed multiply-accumulate with a saturating accumulator.
// Assumes ACC_W >= 2*DW; one guard bit detects overflow on each addition.
module comp_mac #(
    parameter int DW    = 16,
    parameter int ACC_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     en,
    input  logic [DW-1:0]            coef,
    input  logic [DW-1:0]            operand,
    output logic signed [ACC_W-1:0]  acc
);
    localparam int PW = 2 * DW;

    logic signed [PW-1:0]    prod;
    logic signed [ACC_W:0]   sum;
    logic signed [ACC_W-1:0] acc_next;

    assign prod = $signed(coef) * $signed(operand);
    assign sum  = $signed({acc[ACC_W-1], acc})
                + $signed({{(ACC_W+1-PW){prod[PW-1]}}, prod});

    // Saturate when the guard bit disagrees with the sign bit
    always_comb begin
        if (sum[ACC_W] != sum[ACC_W-1])
            acc_next = sum[ACC_W] ? {1'b1, {(ACC_W-1){1'b0}}}
                                  : {1'b0, {(ACC_W-1){1'b1}}};
        else
            acc_next = sum[ACC_W-1:0];
    end

    // Clear on accept, accumulate one product per step
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            acc <= '0;
        else if (en)
            acc <= acc_next;
    end

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en && !clr && acc > 0 && prod > 0 |=> acc > 0);

    // R4
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en && !clr && acc < 0 && prod < 0 |=> acc < 0);
endmodule

// File: rtl/comp_post.sv
// comp_post: gain, arithmetic shift and clamp of the accumulated sum,
// plus the duty and done registers. Assumes the limits are signed.
module comp_post #(
    parameter int DW    = 16,
    parameter int ACC_W = 32,
    parameter int SH_W  = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    upd,
    input  logic signed [ACC_W-1:0] acc,
    input  logic [DW-1:0]           scale,
    input  logic [SH_W-1:0]         shift,
    input  logic [DW-1:0]           lo,
    input  logic [DW-1:0]           hi,
    output logic [DW-1:0]           clamped,
    output logic [DW-1:0]           duty,
    output logic                    done
);
    localparam int SC_W = ACC_W + DW;

    logic signed [SC_W-1:0] scaled;
    logic signed [SC_W-1:0] shifted;
    logic signed [SC_W-1:0] lo_x;
    logic signed [SC_W-1:0] hi_x;

    assign scaled  = acc * $signed(scale);
    assign shifted = scaled >>> shift;
    assign lo_x    = $signed({{(SC_W-DW){lo[DW-1]}}, lo});
    assign hi_x    = $signed({{(SC_W-DW){hi[DW-1]}}, hi});

    // Upper limit first, then lower limit
    always_comb begin
        if (shifted > hi_x)
            clamped = hi;
        else if (shifted < lo_x)
            clamped = lo;
        else
            clamped = shifted[DW-1:0];
    end

    // Register the command and flag it for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty <= '0;
            done <= 1'b0;
        end else begin
            done <= upd;
            if (upd)
                duty <= clamped;
        end
    end

    // R6
    clamp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && ($signed(lo) <= $signed(hi))
        |-> ($signed(duty) >= $signed(lo)) && ($signed(duty) <= $signed(hi)));

    // R6
    duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(duty));
endmodule

// File: rtl/comp3p3z.sv
// comp3p3z: third-order compensator top. Sequences seven MAC steps after
// an accepted start, then one post-processing step that drives duty,
// raises done and advances the histories. Assumes a single clock domain
// and that start, abort and configuration are synchronous to it.
module comp3p3z
    import comp_pkg::*;
#(
    parameter int SAMP_W = 12,
    parameter int DW     = 16,
    parameter int ACC_W  = 32,
    parameter int SH_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DW-1:0]     cfg_wdata,
    input  logic              hist_clr,
    input  logic              start,
    input  logic              abort,
    input  logic [SAMP_W-1:0] setpoint,
    input  logic [SAMP_W-1:0] sample,
    output logic              busy,
    output logic              done,
    output logic [DW-1:0]     duty
);
    localparam int                STEP_W    = $clog2(NTERM + 1);
    localparam int                NSLOTS    = 2 ** STEP_W;
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NTERM);

    logic [STEP_W-1:0]          step;
    logic                       accept, mac_en, finish, clr_go;
    logic [NTERM-1:0][DW-1:0]   coef;
    logic [NSLOTS-1:0][DW-1:0]  coef_pad;
    logic [DW-1:0]              coef_sel, operand, clamped;
    logic [DW-1:0]              scale, lo, hi;
    logic [SH_W-1:0]            shift;
    logic signed [ACC_W-1:0]    acc;

    assign accept = start && !busy && !abort;
    assign mac_en = busy && !abort && (step != LAST_STEP);
    assign finish = busy && !abort && (step == LAST_STEP);
    assign clr_go = hist_clr && !busy;

    // Step sequencer: NTERM product steps, then one finishing step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            step <= '0;
        end else if (accept) begin
            busy <= 1'b1;
            step <= '0;
        end else if (busy) begin
            if (abort || step == LAST_STEP) begin
                busy <= 1'b0;
                step <= '0;
            end else begin
                step <= step + 1'b1;
            end
        end
    end

    // Coefficient table indexed by step, padded with zeros
    for (genvar k = 0; k < NSLOTS; k++) begin : g_cpad
        if (k < NTERM) begin : g_used
            assign coef_pad[k] = coef[k];
        end else begin : g_pad
            assign coef_pad[k] = '0;
        end
    end
    assign coef_sel = coef_pad[step];

    comp_cfg #(.DW(DW), .SH_W(SH_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .busy  (busy),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .coef  (coef),
        .scale (scale),
        .shift (shift),
        .lo    (lo),
        .hi    (hi)
    );

    comp_hist #(.SAMP_W(SAMP_W), .DW(DW), .SEL_W(STEP_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (accept),
        .setpoint (setpoint),
        .sample   (sample),
        .clr      (clr_go),
        .advance  (finish),
        .newest   (clamped),
        .sel      (step),
        .operand  (operand)
    );

    comp_mac #(.DW(DW), .ACC_W(ACC_W)) u_mac (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (accept),
        .en      (mac_en),
        .coef    (coef_sel),
        .operand (operand),
        .acc     (acc)
    );

    comp_post #(.DW(DW), .ACC_W(ACC_W), .SH_W(SH_W)) u_post (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd     (finish),
        .acc     (acc),
        .scale   (scale),
        .shift   (shift),
        .lo      (lo),
        .hi      (hi),
        .clamped (clamped),
        .duty    (duty),
        .done    (done)
    );

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy && step == '0);

    // R3
    done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && $past(busy));

    // R9
    abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && abort |=> !busy && !done);

    // R11
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start && !abort && step != LAST_STEP
        |=> busy && step == $past(step) + 1'b1);
endmodule

// File: tb/tb_comp3p3z.sv
`timescale 1ns/1ps
module tb_comp3p3z;
    localparam int ACC_W = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        hist_clr = 1'b0;
    logic        start = 1'b0;
    logic        abort = 1'b0;
    logic [11:0] setpoint = '0;
    logic [11:0] sample = '0;
    logic        busy, done;
    logic [15:0] duty;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // arithmetic model state
    int mb[4];
    int ma[3];
    int msc, msh, mlo, mhi;
    int me[3];
    int mu[3];

    always #2.5 clk = ~clk;

    comp3p3z dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .hist_clr(hist_clr), .start(start),
        .abort(abort), .setpoint(setpoint), .sample(sample),
        .busy(busy), .done(done), .duty(duty)
    );

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint sat_acc(longint v);
        longint maxv;
        longint minv;
        maxv = (longint'(1) <<< (ACC_W-1)) - 1;
        minv = -(longint'(1) <<< (ACC_W-1));
        if (v > maxv) return maxv;
        if (v < minv) return minv;
        return v;
    endfunction

    function automatic int model(int sp, int fb);
        longint acc;
        longint v;
        int e0;
        e0 = sp - fb;
        acc = 0;
        acc = sat_acc(acc + longint'(mb[0]) * longint'(e0));
        for (int i = 1; i < 4; i++) acc = sat_acc(acc + longint'(mb[i]) * longint'(me[i-1]));
        for (int j = 0; j < 3; j++) acc = sat_acc(acc + longint'(ma[j]) * longint'(mu[j]));
        v = (acc * longint'(msc)) >>> msh;
        if (v > longint'(mhi)) return mhi;
        if (v < longint'(mlo)) return mlo;
        return int'(v);
    endfunction

    task automatic wr(int a, int d);
        int sv;
        sv = int'($signed(16'(d)));
        cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 16'(d);
        @(negedge clk);
        cfg_we = 1'b0;
        if (a < 4) mb[a] = sv;
        else if (a < 7) ma[a-4] = sv;
        else if (a == 7) msc = sv;
        else if (a == 8) msh = d & 31;
        else if (a == 9) mlo = sv;
        else if (a == 10) mhi = sv;
    endtask

    task automatic set_coefs(int b0, int b1, int b2, int b3, int a1, int a2, int a3);
        wr(0, b0); wr(1, b1); wr(2, b2); wr(3, b3);
        wr(4, a1); wr(5, a2); wr(6, a3);
    endtask

    task automatic clear_hist();
        hist_clr = 1'b1;
        @(negedge clk);
        hist_clr = 1'b0;
        for (int i = 0; i < 3; i++) begin me[i] = 0; mu[i] = 0; end
    endtask

    // mode 0 normal, 1 second start while busy, 2 write while busy, 3 abort
    task automatic run(int sp, int fb, int mode, string req);
        int exp_v;
        int n_done;
        int first_k;
        int got;
        int prev_duty;
        exp_v = model(sp, fb);
        n_done = 0; first_k = 0; got = 0;
        prev_duty = int'($signed(duty));
        setpoint = 12'(sp); sample = 12'(fb); start = 1'b1;
        for (int k = 1; k <= 11; k++) begin
            @(negedge clk);
            if (done) begin
                n_done++;
                if (first_k == 0) first_k = k;
                got = int'($signed(duty));
            end
            if (k == 5) check(busy == (mode != 3), "R3 busy", int'(busy), int'(mode != 3));
            if (k == 1) start = 1'b0;
            if (mode == 1 && k == 3) begin start = 1'b1; setpoint = 12'(4095 - sp); end
            if (mode == 1 && k == 4) start = 1'b0;
            if (mode == 2 && k == 3) begin cfg_we = 1'b1; cfg_addr = 4'd0; cfg_wdata = 16'h1234; end
            if (mode == 2 && k == 4) cfg_we = 1'b0;
            if (mode == 3 && k == 4) abort = 1'b1;
            if (mode == 3 && k == 5) abort = 1'b0;
        end
        if (mode == 3) begin
            check(n_done == 0, "R9 no done", n_done, 0);
            check(int'($signed(duty)) == prev_duty, "R9 duty kept", int'($signed(duty)), prev_duty);
        end else begin
            check(n_done == 1, "R3 single done", n_done, 1);
            check(first_k == 9, "R3 done latency", first_k, 9);
            check(got == exp_v, req, got, exp_v);
            me[2] = me[1]; me[1] = me[0]; me[0] = sp - fb;
            mu[2] = mu[1]; mu[1] = mu[0]; mu[0] = exp_v;
        end
    endtask

    initial begin
        for (int i = 0; i < 4; i++) mb[i] = 0;
        for (int i = 0; i < 3; i++) begin ma[i] = 0; me[i] = 0; mu[i] = 0; end
        msc = 1; msh = 0; mlo = 0; mhi = 32767;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        check(duty == 16'd0, "R10 reset duty", int'(duty), 0);
        check(!done, "R3 reset done", int'(done), 0);
        check(!busy, "R3 reset busy", int'(busy), 0);

        // R10 reset gain 1 and shift 0: B0 alone passes the error
        wr(0, 1);
        run(100, 0, 0, "R10 reset gain");

        // R1 error sweep across the sample range
        wr(9, -32768);
        for (int s = 0; s < 3; s++) begin
            for (int fb = 0; fb < 4096; fb += 65) begin
                run((s == 0) ? 0 : ((s == 1) ? 2048 : 4095), fb, 0, "R1 error");
            end
        end

        // R2 and R7 mixed coefficient sets over several updates
        for (int set = 0; set < 4; set++) begin
            set_coefs(((set*37) % 200) - 100, ((set*37 + 53) % 200) - 100,
                      ((set*37 + 106) % 200) - 100, ((set*37 + 159) % 200) - 100,
                      ((set*29) % 120) - 60, ((set*29 + 71) % 120) - 60,
                      ((set*29 + 142) % 120) - 60);
            wr(7, 1 + set*3); wr(8, set + 2); wr(9, -2000); wr(10, 2000);
            clear_hist();
            for (int n = 0; n < 10; n++)
                run((n*397 + set*111) % 4096, (n*911 + 55) % 4096, 0, "R2 R7 sum");
        end

        // R5 every shift amount, both signs
        set_coefs(1000, 0, 0, 0, 0, 0, 0);
        wr(7, 300); wr(9, -32768); wr(10, 32767);
        for (int s = 0; s < 32; s++) begin
            wr(8, s);
            run(4000, 0, 0, "R5 shift pos");
            run(0, 4000, 0, "R5 shift neg");
        end

        // R6 clamp window
        set_coefs(1, 0, 0, 0, 0, 0, 0);
        wr(7, 1); wr(8, 0); wr(9, 100); wr(10, 200);
        for (int d = -50; d <= 350; d += 25) run(1000 + d, 1000, 0, "R6 clamp");

        // R4 positive saturation
        clear_hist();
        set_coefs(32767, 0, 0, 0, 32767, 32767, 32767);
        wr(8, 0); wr(9, -32768); wr(10, 32767);
        for (int n = 0; n < 3; n++) run(4095, 0, 0, "R4 fill");
        wr(8, 20);
        run(4095, 0, 0, "R4 sat high");
        // R4 negative saturation
        clear_hist();
        wr(8, 0);
        for (int n = 0; n < 3; n++) run(0, 4095, 0, "R4 fill");
        wr(8, 20);
        run(0, 4095, 0, "R4 sat low");

        // R8 clear empties the output history
        set_coefs(0, 0, 0, 0, 1, 1, 1);
        wr(8, 0);
        clear_hist();
        run(500, 0, 0, "R8 cleared");
        check(duty == 16'd0, "R8 zero after clear", int'($signed(duty)), 0);

        // R9 abort keeps histories
        set_coefs(1, 0, 0, 0, 1, 0, 0);
        clear_hist();
        run(300, 100, 0, "R9 setup");
        run(300, 100, 0, "R9 setup");
        run(300, 100, 3, "R9");
        run(300, 100, 0, "R9 history kept");

        // R11 start while busy is ignored
        run(700, 200, 1, "R11 late start");
        run(700, 200, 0, "R11 after");

        // R10 write while busy is ignored
        run(900, 100, 2, "R10 busy write");
        run(900, 100, 0, "R10 coefficient kept");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule